// File: doc/BRIEF.md
# Single-Cycle 32-bit Integer Processor Core

This block is a small load-store processor that completes one instruction on every clock edge. Each cycle it fetches a 32-bit word from an internal instruction store, decodes it and reads two source registers. It then computes a result or an address, optionally reads or writes an internal data store, writes at most one register and selects the next program counter. It covers integer add, subtract, bitwise and, or and xor, signed and unsigned set-less-than, add-immediate, word load and store, equal and not-equal branches, region jumps, jump-and-link and jump-through-register.

The surrounding logic fills the instruction store through a write port while reset is held. Execution starts at address 0 once reset is released. Results are observed through an asynchronous read port on the data store and through the current program counter.

The next address comes from one of four selections. Sequential gives PC+4. Branch gives PC+4 or the branch target. Region gives the top bits of PC+4 joined with a 26-bit field. Register gives the value of a register.

Top module: `sc_core`

## Requirements
- R1: While `rst_n` is low the program counter reads 0 and all 32 registers are cleared, so a register stored to memory right after reset gives 0.
- R2: Register 0 reads as zero in every instruction, and a write aimed at it leaves it zero.
- R3: With opcode 000000 (bits 31:26) the function code in bits 5:0 selects add 100000, sub 100010, and 100100, or 100101, xor 100110. The result of rs (bits 25:21) and rt (bits 20:16) is written to rd (bits 15:11), and rd may equal a source.
- R4: Function 101010 writes 1 to rd when rs < rt as signed two's complement, else 0. Function 101011 makes the same comparison unsigned, so all-ones compares greater than 1.
- R5: Opcode 001000 adds the sign-extended 16-bit immediate (bits 15:0) to rs and writes rt.
- R6: Opcode 100011 loads rt from the data word at rs + sign-extended immediate, and opcode 101011 stores rt there. The word index is address bits [DAW+1:2]. No other instruction writes the data store, and `dbg_addr` reads any data word combinationally.
- R7: Every instruction that is not a branch or jump advances the program counter by 4.
- R8: Opcode 000100 (equal) and 000101 (not equal) compare rs and rt. When taken, the next PC is PC+4 plus the sign-extended offset shifted left by 2, otherwise PC+4.
- R9: Opcode 000010 jumps, and opcode 000011 also writes PC+4 to register 31. Both jump to {PC+4[31:28], bits 25:0, 00}.
- R10: Opcode 000000 with function 001000 loads the program counter from rs.
- R11: An opcode or register-format function code outside this set writes no register and no memory, and only advances the PC by 4.
- R12: With `imem_we` high, `imem_wdata` is written at the next clock edge into instruction word `imem_waddr`. The instruction fetched is word PC[IAW+1:2].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| imem_we | input | 1 | Instruction store write enable |
| imem_waddr | input | IAW | Instruction word index to write |
| imem_wdata | input | 32 | Instruction word to write |
| dbg_addr | input | DAW | Data word index for the debug read |
| dbg_rdata | output | 32 | Data word at `dbg_addr` |
| pc_o | output | 32 | Current program counter |

## Verification
Register contents never reach a port, so every check goes through a program that ends by storing the registers of interest to known data words and then parks in a jump-to-itself loop. The hardest case to reach is an instruction that must have no effect: an unknown encoding, a write to register 0, or a branch that skips a write. The target word is therefore first filled with a different value by an earlier store in the same program. A missing or stray write then shows up as a changed word. Return linkage is checked by storing register 31 from inside the called routine, then returning through it to a store that marks the return path.

// File: rtl/sc_pkg.sv
`timescale 1ns/1ps
package sc_pkg;
    localparam int XLEN      = 32;
    localparam int REG_COUNT = 32;
    localparam int RIDX_W    = $clog2(REG_COUNT);

    // primary opcodes, bits 31:26
    localparam logic [5:0] OP_RTYPE = 6'b000000;
    localparam logic [5:0] OP_J     = 6'b000010;
    localparam logic [5:0] OP_JAL   = 6'b000011;
    localparam logic [5:0] OP_BEQ   = 6'b000100;
    localparam logic [5:0] OP_BNE   = 6'b000101;
    localparam logic [5:0] OP_ADDI  = 6'b001000;
    localparam logic [5:0] OP_LW    = 6'b100011;
    localparam logic [5:0] OP_SW    = 6'b101011;

    // register-format function codes, bits 5:0
    localparam logic [5:0] FN_JR   = 6'b001000;
    localparam logic [5:0] FN_ADD  = 6'b100000;
    localparam logic [5:0] FN_SUB  = 6'b100010;
    localparam logic [5:0] FN_AND  = 6'b100100;
    localparam logic [5:0] FN_OR   = 6'b100101;
    localparam logic [5:0] FN_XOR  = 6'b100110;
    localparam logic [5:0] FN_SLT  = 6'b101010;
    localparam logic [5:0] FN_SLTU = 6'b101011;

    typedef enum logic [3:0] {
        K_NOP, K_ADD, K_SUB, K_AND, K_OR, K_XOR, K_SLT, K_SLTU,
        K_ADDI, K_LW, K_SW, K_BEQ, K_BNE, K_J, K_JAL, K_JR
    } kind_e;

    typedef enum logic [2:0] {
        ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_XOR, ALU_SLT, ALU_SLTU
    } alu_op_e;

    typedef enum logic [1:0] { DST_NONE, DST_RD, DST_RT, DST_LINK } dst_e;
    typedef enum logic [1:0] { WB_ALU, WB_MEM, WB_LINK } wb_e;
    typedef enum logic [1:0] { PC_SEQ, PC_BRANCH, PC_REGION, PC_REG } pc_sel_e;

    typedef struct packed {
        kind_e   kind;
        alu_op_e alu_op;
        logic    use_imm;
        dst_e    dst;
        wb_e     wb;
        logic    mem_we;
        pc_sel_e pc_sel;
    } ctrl_t;
endpackage

// File: rtl/sc_imem.sv
`timescale 1ns/1ps
module sc_imem #(
    parameter int WORDS = 64,
    parameter int W     = 32,
    localparam int AW   = $clog2(WORDS)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] store [WORDS];

    always_ff @(posedge clk) begin
        if (we) begin
            store[waddr] <= wdata;
        end
    end

    assign rdata = store[raddr];
endmodule

// File: rtl/sc_dmem.sv
`timescale 1ns/1ps
module sc_dmem #(
    parameter int WORDS = 64,
    parameter int W     = 32,
    localparam int AW   = $clog2(WORDS)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  rdata,
    input  logic [AW-1:0] peek_addr,
    output logic [W-1:0]  peek_data
);
    logic [W-1:0] store [WORDS];

    always_ff @(posedge clk) begin
        if (we) begin
            store[addr] <= wdata;
        end
    end

    assign rdata     = store[addr];
    assign peek_data = store[peek_addr];
endmodule

// File: rtl/sc_regfile.sv
`timescale 1ns/1ps
module sc_regfile #(
    parameter int N        = 32,
    parameter int W        = 32,
    parameter int RD_PORTS = 2,
    localparam int AW      = $clog2(N)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [RD_PORTS-1:0][AW-1:0]  raddr,
    output logic [RD_PORTS-1:0][W-1:0]   rdata,
    input  logic                         we,
    input  logic [AW-1:0]                waddr,
    input  logic [W-1:0]                 wdata
);
    logic [W-1:0] regs [N];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) begin
                regs[i] <= '0;
            end
        end else if (we && (waddr != '0)) begin
            regs[waddr] <= wdata;
        end
    end

    for (genvar p = 0; p < RD_PORTS; p++) begin : g_rd
        assign rdata[p] = (raddr[p] == '0) ? '0 : regs[raddr[p]];
    end
endmodule

// File: rtl/sc_decode.sv
`timescale 1ns/1ps
module sc_decode
    import sc_pkg::*;
(
    input  logic [XLEN-1:0]   instr,
    output ctrl_t             ctrl,
    output logic [RIDX_W-1:0] rs,
    output logic [RIDX_W-1:0] rt,
    output logic [RIDX_W-1:0] rd,
    output logic [XLEN-1:0]   imm_sx,
    output logic [25:0]       target
);
    logic [5:0] opcode;
    logic [5:0] funct;
    logic [4:0] unused_shamt;

    assign opcode       = instr[31:26];
    assign rs           = instr[25:21];
    assign rt           = instr[20:16];
    assign rd           = instr[15:11];
    assign unused_shamt = instr[10:6];
    assign funct        = instr[5:0];
    assign imm_sx       = {{(XLEN-16){instr[15]}}, instr[15:0]};
    assign target       = instr[25:0];

    always_comb begin
        ctrl = '{kind: K_NOP, alu_op: ALU_ADD, use_imm: 1'b0, dst: DST_NONE,
                 wb: WB_ALU, mem_we: 1'b0, pc_sel: PC_SEQ};
        unique case (opcode)
            OP_RTYPE: begin
                unique case (funct)
                    FN_ADD:  begin ctrl.kind = K_ADD;  ctrl.alu_op = ALU_ADD;  ctrl.dst = DST_RD; end
                    FN_SUB:  begin ctrl.kind = K_SUB;  ctrl.alu_op = ALU_SUB;  ctrl.dst = DST_RD; end
                    FN_AND:  begin ctrl.kind = K_AND;  ctrl.alu_op = ALU_AND;  ctrl.dst = DST_RD; end
                    FN_OR:   begin ctrl.kind = K_OR;   ctrl.alu_op = ALU_OR;   ctrl.dst = DST_RD; end
                    FN_XOR:  begin ctrl.kind = K_XOR;  ctrl.alu_op = ALU_XOR;  ctrl.dst = DST_RD; end
                    FN_SLT:  begin ctrl.kind = K_SLT;  ctrl.alu_op = ALU_SLT;  ctrl.dst = DST_RD; end
                    FN_SLTU: begin ctrl.kind = K_SLTU; ctrl.alu_op = ALU_SLTU; ctrl.dst = DST_RD; end
                    FN_JR:   begin ctrl.kind = K_JR;   ctrl.pc_sel = PC_REG; end
                    default: ;
                endcase
            end
            OP_ADDI: begin
                ctrl.kind    = K_ADDI;
                ctrl.use_imm = 1'b1;
                ctrl.dst     = DST_RT;
            end
            OP_LW: begin
                ctrl.kind    = K_LW;
                ctrl.use_imm = 1'b1;
                ctrl.dst     = DST_RT;
                ctrl.wb      = WB_MEM;
            end
            OP_SW: begin
                ctrl.kind    = K_SW;
                ctrl.use_imm = 1'b1;
                ctrl.mem_we  = 1'b1;
            end
            OP_BEQ: begin
                ctrl.kind   = K_BEQ;
                ctrl.pc_sel = PC_BRANCH;
            end
            OP_BNE: begin
                ctrl.kind   = K_BNE;
                ctrl.pc_sel = PC_BRANCH;
            end
            OP_J: begin
                ctrl.kind   = K_J;
                ctrl.pc_sel = PC_REGION;
            end
            OP_JAL: begin
                ctrl.kind   = K_JAL;
                ctrl.pc_sel = PC_REGION;
                ctrl.dst    = DST_LINK;
                ctrl.wb     = WB_LINK;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/sc_alu.sv
`timescale 1ns/1ps
module sc_alu
    import sc_pkg::*;
(
    input  alu_op_e         op,
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    output logic [XLEN-1:0] y
);
    logic lt_signed;
    logic lt_unsigned;

    assign lt_signed   = $signed(a) < $signed(b);
    assign lt_unsigned = a < b;

    always_comb begin
        unique case (op)
            ALU_ADD:  y = a + b;
            ALU_SUB:  y = a - b;
            ALU_AND:  y = a & b;
            ALU_OR:   y = a | b;
            ALU_XOR:  y = a ^ b;
            ALU_SLT:  y = {{(XLEN-1){1'b0}}, lt_signed};
            ALU_SLTU: y = {{(XLEN-1){1'b0}}, lt_unsigned};
            default:  y = a + b;
        endcase
    end
endmodule

// File: rtl/sc_core.sv
`timescale 1ns/1ps
module sc_core
    import sc_pkg::*;
#(
    parameter int  IMEM_WORDS = 64,
    parameter int  DMEM_WORDS = 64,
    localparam int IAW        = $clog2(IMEM_WORDS),
    localparam int DAW        = $clog2(DMEM_WORDS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            imem_we,
    input  logic [IAW-1:0]  imem_waddr,
    input  logic [31:0]     imem_wdata,
    input  logic [DAW-1:0]  dbg_addr,
    output logic [31:0]     dbg_rdata,
    output logic [31:0]     pc_o
);
    logic [XLEN-1:0]   pc_q;
    logic [XLEN-1:0]   pc_next;
    logic [XLEN-1:0]   pc_plus4;
    logic [XLEN-1:0]   br_target;
    logic [XLEN-1:0]   instr;

    ctrl_t             ctrl;
    logic [RIDX_W-1:0] rs_idx;
    logic [RIDX_W-1:0] rt_idx;
    logic [RIDX_W-1:0] rd_idx;
    logic [XLEN-1:0]   imm_sx;
    logic [25:0]       jtarget;

    logic [1:0][XLEN-1:0] rd_bus;
    logic [XLEN-1:0]   rs_data;
    logic [XLEN-1:0]   rt_data;
    logic [XLEN-1:0]   alu_b;
    logic [XLEN-1:0]   alu_y;
    logic [XLEN-1:0]   mem_rdata;
    logic              dmem_we;

    logic              rf_we;
    logic [RIDX_W-1:0] rf_waddr;
    logic [XLEN-1:0]   rf_wdata;
    logic              br_taken;

    // fetch
    sc_imem #(.WORDS(IMEM_WORDS), .W(XLEN)) u_imem (
        .clk   (clk),
        .we    (imem_we),
        .waddr (imem_waddr),
        .wdata (imem_wdata),
        .raddr (pc_q[IAW+1:2]),
        .rdata (instr)
    );

    // decode
    sc_decode u_decode (
        .instr  (instr),
        .ctrl   (ctrl),
        .rs     (rs_idx),
        .rt     (rt_idx),
        .rd     (rd_idx),
        .imm_sx (imm_sx),
        .target (jtarget)
    );

    // operand fetch and write-back
    sc_regfile #(.N(REG_COUNT), .W(XLEN), .RD_PORTS(2)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .raddr ({rt_idx, rs_idx}),
        .rdata (rd_bus),
        .we    (rf_we),
        .waddr (rf_waddr),
        .wdata (rf_wdata)
    );

    assign rs_data = rd_bus[0];
    assign rt_data = rd_bus[1];

    // execute
    assign alu_b = ctrl.use_imm ? imm_sx : rt_data;

    sc_alu u_alu (
        .op (ctrl.alu_op),
        .a  (rs_data),
        .b  (alu_b),
        .y  (alu_y)
    );

    // data access
    assign dmem_we = ctrl.mem_we;

    sc_dmem #(.WORDS(DMEM_WORDS), .W(XLEN)) u_dmem (
        .clk       (clk),
        .we        (dmem_we),
        .addr      (alu_y[DAW+1:2]),
        .wdata     (rt_data),
        .rdata     (mem_rdata),
        .peek_addr (dbg_addr),
        .peek_data (dbg_rdata)
    );

    // destination and result selection
    always_comb begin
        rf_we    = 1'b1;
        rf_waddr = '0;
        unique case (ctrl.dst)
            DST_NONE: rf_we    = 1'b0;
            DST_RD:   rf_waddr = rd_idx;
            DST_RT:   rf_waddr = rt_idx;
            DST_LINK: rf_waddr = '1;
            default:  rf_we    = 1'b0;
        endcase
    end

    always_comb begin
        unique case (ctrl.wb)
            WB_ALU:  rf_wdata = alu_y;
            WB_MEM:  rf_wdata = mem_rdata;
            WB_LINK: rf_wdata = pc_plus4;
            default: rf_wdata = alu_y;
        endcase
    end

    // next-PC selection
    assign pc_plus4  = pc_q + XLEN'(4);
    assign br_target = pc_plus4 + {imm_sx[XLEN-3:0], 2'b00};
    assign br_taken  = ((ctrl.kind == K_BEQ) && (rs_data == rt_data)) ||
                       ((ctrl.kind == K_BNE) && (rs_data != rt_data));

    always_comb begin
        unique case (ctrl.pc_sel)
            PC_SEQ:    pc_next = pc_plus4;
            PC_BRANCH: pc_next = br_taken ? br_target : pc_plus4;
            PC_REGION: pc_next = {pc_plus4[XLEN-1:28], jtarget, 2'b00};
            PC_REG:    pc_next = rs_data;
            default:   pc_next = pc_plus4;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_q <= '0;
        end else begin
            pc_q <= pc_next;
        end
    end

    assign pc_o = pc_q;
endmodule

// File: rtl/sc_core_chk.sv
`timescale 1ns/1ps
module sc_core_chk
    import sc_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [XLEN-1:0]   pc,
    input kind_e             kind,
    input logic [RIDX_W-1:0] rs_idx,
    input logic [XLEN-1:0]   rs_data,
    input logic [XLEN-1:0]   rt_data,
    input logic [XLEN-1:0]   imm_sx,
    input logic              rf_we,
    input logic [RIDX_W-1:0] rf_waddr,
    input logic [XLEN-1:0]   rf_wdata,
    input logic              dmem_we
);
    logic is_ctl;
    assign is_ctl = (kind == K_BEQ) || (kind == K_BNE) || (kind == K_J) ||
                    (kind == K_JAL) || (kind == K_JR);

    a_r1_pc_from_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (pc == '0));

    a_r2_zero_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rs_idx == '0) |-> (rs_data == '0));

    a_r6_store_only_writes: assert property (@(posedge clk) disable iff (!rst_n)
        dmem_we |-> (kind == K_SW));

    a_r7_seq_advance: assert property (@(posedge clk) disable iff (!rst_n)
        !is_ctl |=> (pc == $past(pc) + 32'd4));

    a_r8_beq_taken: assert property (@(posedge clk) disable iff (!rst_n)
        ((kind == K_BEQ) && (rs_data == rt_data)) |=>
            (pc == $past(pc) + 32'd4 + {$past(imm_sx[XLEN-3:0]), 2'b00}));

    a_r9_link_write: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == K_JAL) |-> (rf_we && (rf_waddr == '1) && (rf_wdata == pc + 32'd4)));

    a_r10_reg_jump: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == K_JR) |=> (pc == $past(rs_data)));

    a_r11_unknown_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == K_NOP) |-> (!rf_we && !dmem_we));
endmodule

bind sc_core sc_core_chk i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .pc       (pc_q),
    .kind     (ctrl.kind),
    .rs_idx   (rs_idx),
    .rs_data  (rs_data),
    .rt_data  (rt_data),
    .imm_sx   (imm_sx),
    .rf_we    (rf_we),
    .rf_waddr (rf_waddr),
    .rf_wdata (rf_wdata),
    .dmem_we  (dmem_we)
);

// File: tb/test_sc_core.sv
`timescale 1ns/1ps
module test_sc_core;
    import sc_pkg::*;

    localparam int IW  = 64;
    localparam int DW  = 64;
    localparam int IAW = $clog2(IW);
    localparam int DAW = $clog2(DW);

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           imem_we = 1'b0;
    logic [IAW-1:0] imem_waddr = '0;
    logic [31:0]    imem_wdata = '0;
    logic [DAW-1:0] dbg_addr = '0;
    logic [31:0]    dbg_rdata;
    logic [31:0]    pc_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    logic [31:0] prog [IW];

    always #2.5 clk = ~clk;

    sc_core #(.IMEM_WORDS(IW), .DMEM_WORDS(DW)) i_sc_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .imem_we    (imem_we),
        .imem_waddr (imem_waddr),
        .imem_wdata (imem_wdata),
        .dbg_addr   (dbg_addr),
        .dbg_rdata  (dbg_rdata),
        .pc_o       (pc_o)
    );

    function automatic logic [31:0] f_r(input logic [5:0] fn, input logic [4:0] s,
                                        input logic [4:0] t, input logic [4:0] d);
        return {OP_RTYPE, s, t, d, 5'd0, fn};
    endfunction

    function automatic logic [31:0] f_i(input logic [5:0] op, input logic [4:0] s,
                                        input logic [4:0] t, input logic [15:0] imm);
        return {op, s, t, imm};
    endfunction

    function automatic logic [31:0] f_j(input logic [5:0] op, input logic [25:0] tg);
        return {op, tg};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic chk_mem(input string req, input int idx, input logic [31:0] exp);
        logic [31:0] v;
        dbg_addr = DAW'(idx);
        #1;
        v = dbg_rdata;
        chk(req, v, exp);
        @(negedge clk);
    endtask

    task automatic clear_prog();
        for (int i = 0; i < IW; i++) prog[i] = 32'h0;
    endtask

    task automatic load_prog();
        @(negedge clk);
        rst_n = 1'b0;
        for (int i = 0; i < IW; i++) begin
            imem_we    = 1'b1;
            imem_waddr = IAW'(i);
            imem_wdata = prog[i];
            @(negedge clk);
        end
        imem_we = 1'b0;
    endtask

    task automatic go(input int cycles);
        rst_n = 1'b1;
        repeat (cycles) @(negedge clk);
    endtask

    // R3 R5 R7 R12: arithmetic, logic and immediates, PC stepping
    task automatic t_arith();
        clear_prog();
        prog[0]  = f_i(OP_ADDI, 5'd0, 5'd1, 16'h0005);
        prog[1]  = f_i(OP_ADDI, 5'd0, 5'd2, 16'hFFFD);
        prog[2]  = f_r(FN_ADD, 5'd1, 5'd2, 5'd3);
        prog[3]  = f_r(FN_SUB, 5'd1, 5'd2, 5'd4);
        prog[4]  = f_r(FN_AND, 5'd1, 5'd2, 5'd5);
        prog[5]  = f_r(FN_OR,  5'd1, 5'd2, 5'd6);
        prog[6]  = f_r(FN_XOR, 5'd1, 5'd2, 5'd7);
        prog[7]  = f_r(FN_ADD, 5'd1, 5'd1, 5'd1);
        prog[8]  = f_i(OP_SW, 5'd0, 5'd3, 16'd0);
        prog[9]  = f_i(OP_SW, 5'd0, 5'd4, 16'd4);
        prog[10] = f_i(OP_SW, 5'd0, 5'd5, 16'd8);
        prog[11] = f_i(OP_SW, 5'd0, 5'd6, 16'd12);
        prog[12] = f_i(OP_SW, 5'd0, 5'd7, 16'd16);
        prog[13] = f_i(OP_SW, 5'd0, 5'd1, 16'd20);
        prog[14] = f_i(OP_SW, 5'd0, 5'd2, 16'd24);
        prog[15] = f_j(OP_J, 26'd15);
        load_prog();
        go(1);
        chk("R7 pc after 1 step", pc_o, 32'd4);
        @(negedge clk);
        chk("R7 pc after 2 steps", pc_o, 32'd8);
        @(negedge clk);
        chk("R12 pc after 3 steps", pc_o, 32'd12);
        repeat (20) @(negedge clk);
        chk_mem("R3 add", 0, 32'd2);
        chk_mem("R3 sub", 1, 32'd8);
        chk_mem("R3 and", 2, 32'd5);
        chk_mem("R3 or", 3, 32'hFFFFFFFD);
        chk_mem("R3 xor", 4, 32'hFFFFFFF8);
        chk_mem("R3 same src and dst", 5, 32'd10);
        chk_mem("R5 negative immediate", 6, 32'hFFFFFFFD);
        chk("R9 self loop pc", pc_o, 32'd60);
    endtask

    // R1: reset clears PC and registers
    task automatic t_reset();
        clear_prog();
        prog[0] = f_i(OP_SW, 5'd0, 5'd3, 16'd0);
        prog[1] = f_i(OP_SW, 5'd0, 5'd7, 16'd4);
        prog[2] = f_j(OP_J, 26'd2);
        load_prog();
        chk("R1 pc held at zero", pc_o, 32'd0);
        go(10);
        chk_mem("R1 r3 cleared", 0, 32'd0);
        chk_mem("R1 r7 cleared", 1, 32'd0);
    endtask

    // R2: register zero
    task automatic t_zero();
        clear_prog();
        prog[0] = f_i(OP_ADDI, 5'd0, 5'd1, 16'd3);
        prog[1] = f_i(OP_SW, 5'd0, 5'd1, 16'd32);
        prog[2] = f_i(OP_ADDI, 5'd0, 5'd0, 16'd7);
        prog[3] = f_r(FN_ADD, 5'd1, 5'd1, 5'd0);
        prog[4] = f_i(OP_SW, 5'd0, 5'd0, 16'd32);
        prog[5] = f_r(FN_ADD, 5'd0, 5'd1, 5'd2);
        prog[6] = f_i(OP_SW, 5'd0, 5'd2, 16'd36);
        prog[7] = f_j(OP_J, 26'd7);
        load_prog();
        go(12);
        chk_mem("R2 r0 stays zero", 8, 32'd0);
        chk_mem("R2 r0 as source", 9, 32'd3);
    endtask

    // R4: signed and unsigned compare
    task automatic t_compare();
        clear_prog();
        prog[0]  = f_i(OP_ADDI, 5'd0, 5'd1, 16'd1);
        prog[1]  = f_i(OP_ADDI, 5'd0, 5'd2, 16'hFFFF);
        prog[2]  = f_i(OP_SW, 5'd0, 5'd2, 16'd40);
        prog[3]  = f_i(OP_SW, 5'd0, 5'd2, 16'd44);
        prog[4]  = f_i(OP_SW, 5'd0, 5'd2, 16'd48);
        prog[5]  = f_i(OP_SW, 5'd0, 5'd2, 16'd52);
        prog[6]  = f_i(OP_SW, 5'd0, 5'd2, 16'd56);
        prog[7]  = f_r(FN_SLT,  5'd2, 5'd1, 5'd3);
        prog[8]  = f_r(FN_SLTU, 5'd2, 5'd1, 5'd4);
        prog[9]  = f_r(FN_SLT,  5'd1, 5'd2, 5'd5);
        prog[10] = f_r(FN_SLTU, 5'd1, 5'd2, 5'd6);
        prog[11] = f_r(FN_SLT,  5'd1, 5'd1, 5'd7);
        prog[12] = f_i(OP_SW, 5'd0, 5'd3, 16'd40);
        prog[13] = f_i(OP_SW, 5'd0, 5'd4, 16'd44);
        prog[14] = f_i(OP_SW, 5'd0, 5'd5, 16'd48);
        prog[15] = f_i(OP_SW, 5'd0, 5'd6, 16'd52);
        prog[16] = f_i(OP_SW, 5'd0, 5'd7, 16'd56);
        prog[17] = f_j(OP_J, 26'd17);
        load_prog();
        go(25);
        chk_mem("R4 signed -1 < 1", 10, 32'd1);
        chk_mem("R4 unsigned ones not < 1", 11, 32'd0);
        chk_mem("R4 signed 1 not < -1", 12, 32'd0);
        chk_mem("R4 unsigned 1 < ones", 13, 32'd1);
        chk_mem("R4 equal gives 0", 14, 32'd0);
    endtask

    // R6: loads and stores with positive and negative displacement
    task automatic t_loadstore();
        clear_prog();
        prog[0] = f_i(OP_ADDI, 5'd0, 5'd1, 16'd96);
        prog[1] = f_i(OP_ADDI, 5'd0, 5'd2, 16'h0123);
        prog[2] = f_i(OP_SW, 5'd1, 5'd2, 16'd4);
        prog[3] = f_i(OP_SW, 5'd1, 5'd1, 16'hFFF8);
        prog[4] = f_i(OP_LW, 5'd1, 5'd3, 16'd4);
        prog[5] = f_i(OP_ADDI, 5'd3, 5'd3, 16'd1);
        prog[6] = f_i(OP_SW, 5'd1, 5'd3, 16'hFFFC);
        prog[7] = f_i(OP_LW, 5'd1, 5'd4, 16'hFFF8);
        prog[8] = f_r(FN_ADD, 5'd4, 5'd3, 5'd5);
        prog[9] = f_i(OP_SW, 5'd1, 5'd5, 16'd0);
        prog[10] = f_j(OP_J, 26'd10);
        load_prog();
        go(16);
        chk_mem("R6 store positive disp", 25, 32'h123);
        chk_mem("R6 store negative disp", 22, 32'd96);
        chk_mem("R6 load then add", 23, 32'h124);
        chk_mem("R6 load negative disp", 24, 32'h184);
    endtask

    // R8: branches taken, not taken, backward
    task automatic t_branch();
        clear_prog();
        prog[0]  = f_i(OP_ADDI, 5'd0, 5'd1, 16'd3);
        prog[1]  = f_i(OP_SW, 5'd0, 5'd1, 16'd124);
        prog[2]  = f_i(OP_ADDI, 5'd2, 5'd2, 16'd10);
        prog[3]  = f_i(OP_ADDI, 5'd1, 5'd1, 16'hFFFF);
        prog[4]  = f_i(OP_BNE, 5'd1, 5'd0, 16'hFFFD);
        prog[5]  = f_i(OP_SW, 5'd0, 5'd2, 16'd120);
        prog[6]  = f_i(OP_BEQ, 5'd0, 5'd0, 16'd1);
        prog[7]  = f_i(OP_ADDI, 5'd0, 5'd3, 16'd1);
        prog[8]  = f_i(OP_SW, 5'd0, 5'd3, 16'd124);
        prog[9]  = f_i(OP_BEQ, 5'd2, 5'd0, 16'd1);
        prog[10] = f_i(OP_ADDI, 5'd0, 5'd4, 16'd7);
        prog[11] = f_i(OP_BNE, 5'd4, 5'd4, 16'd1);
        prog[12] = f_i(OP_ADDI, 5'd4, 5'd4, 16'd1);
        prog[13] = f_i(OP_SW, 5'd0, 5'd4, 16'd116);
        prog[14] = f_j(OP_J, 26'd14);
        load_prog();
        go(40);
        chk_mem("R8 backward loop count", 30, 32'd30);
        chk_mem("R8 taken skip", 31, 32'd0);
        chk_mem("R8 not taken falls through", 29, 32'd8);
        chk("R8 final pc", pc_o, 32'd56);
    endtask

    // R9 R10: call and return
    task automatic t_call();
        clear_prog();
        prog[0] = f_j(OP_JAL, 26'd4);
        prog[1] = f_i(OP_SW, 5'd0, 5'd5, 16'd4);
        prog[2] = f_j(OP_J, 26'd2);
        prog[4] = f_i(OP_ADDI, 5'd0, 5'd5, 16'h0055);
        prog[5] = f_i(OP_SW, 5'd0, 5'd31, 16'd0);
        prog[6] = f_r(FN_JR, 5'd31, 5'd0, 5'd0);
        load_prog();
        go(1);
        chk("R9 jal target", pc_o, 32'd16);
        repeat (10) @(negedge clk);
        chk_mem("R9 link value", 0, 32'd4);
        chk_mem("R10 return reached", 1, 32'h55);
        chk("R10 parked pc", pc_o, 32'd8);
    endtask

    // R11: unknown encodings
    task automatic t_unknown();
        clear_prog();
        prog[0] = f_i(OP_ADDI, 5'd0, 5'd1, 16'd9);
        prog[1] = f_i(OP_SW, 5'd0, 5'd1, 16'd160);
        prog[2] = f_r(6'b111111, 5'd0, 5'd0, 5'd1);
        prog[3] = f_i(6'b111111, 5'd0, 5'd1, 16'h00A0);
        prog[4] = f_i(6'b101111, 5'd0, 5'd0, 16'h00A0);
        prog[5] = f_i(OP_SW, 5'd0, 5'd1, 16'd164);
        prog[6] = f_j(OP_J, 26'd6);
        load_prog();
        go(3);
        chk("R11 pc past unknown funct", pc_o, 32'd12);
        repeat (10) @(negedge clk);
        chk_mem("R11 no memory write", 40, 32'd9);
        chk_mem("R11 no register write", 41, 32'd9);
        chk("R11 parked pc", pc_o, 32'd24);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        clear_prog();
        repeat (3) @(negedge clk);
        t_arith();
        t_reset();
        t_zero();
        t_compare();
        t_loadstore();
        t_branch();
        t_call();
        t_unknown();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule